// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Predictor

This block watches the stream of memory accesses issued by a core, each tagged with the program counter of the load or store that made it. It keeps a small direct-mapped table, indexed by low PC bits and guarded by a partial PC tag. For every instruction it remembers the last address, the last observed stride and a saturating confidence count. Because learning is kept separate per instruction, several strided walks that interleave in time (one per instruction) are learned side by side without disturbing each other.

Once an instruction's stride has repeated often enough, the block emits a short burst of predicted addresses, each one stride beyond the previous one, starting from the address just accessed. The addresses leave one at a time through a valid/ready handshake. A fresh access always takes priority: it ends any burst still in progress, and it starts a new one if it is itself confident.

Top module: `stride_pf_table`

## Requirements
- R1: After reset no prefetch is offered (`pfValid` low) and every table entry is empty, so the first access from any PC never causes a prefetch.
- R2: The entry index is `accPc[5:2]` and the tag is `accPc[11:6]`. An access whose tag differs from the stored one, or that finds an empty entry, replaces the entry: it stores the new tag and address, sets the stride to zero and sets the count to zero.
- R3: On an access that hits, the new stride is the access address minus the stored last address, using two's complement wrap, so negative strides work. Every access stores its address as the entry's last address.
- R4: On a hit whose new stride equals the stored stride, the 2-bit count goes up by one and saturates at 3.
- R5: On a hit whose new stride differs, the stored stride is replaced. With the default setting the count drops by one, saturating at 0. With CLEAR_ON_MISS=1 it is cleared instead.
- R6: A burst starts only when the access hits, its updated count is greater than 2 and its stride is nonzero. A steady stream therefore first prefetches on its fifth access.
- R7: A burst offers addr+1·S, addr+2·S, up to addr+4·S (depth 4), where addr is the triggering access address and S is its stride. The first offer appears in the cycle after the access, and each handshake (`pfValid` and `pfReady` with no access in that cycle) moves to the next offer.
- R8: A zero stride never starts a burst, however high the count climbs.
- R9: While `pfValid` is high and `pfReady` is low, with no access arriving, `pfValid` and `pfAddr` hold steady.
- R10: An access arriving during a burst drops the burst's remaining addresses. If that access is confident, a new burst starts from it in the next cycle. If not, `pfValid` is low in the next cycle.
- R11: Strided streams from different PCs that map to different entries, interleaved access by access, each reach confidence on their own fifth access.
- R12: Two PCs that share an index but differ in tag evict each other, so a stream that returns after an eviction must train again before it prefetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A memory access is presented this cycle |
| accPc | input | 32 | PC of the accessing instruction |
| accAddr | input | 32 | Data address of the access |
| pfValid | output | 1 | A prefetch address is offered |
| pfReady | input | 1 | Consumer takes the offered address |
| pfAddr | output | 32 | Offered prefetch address |

## Verification
The hardest situations to reach are the ones where timing and table state overlap. One is an access that lands part-way through a burst. Another is a PC returning after a same-index neighbour has evicted it. Both need a stream that is already confident. The stimulus therefore trains a PC over five accesses and lets a few handshakes go by. It then injects either a continuing access, a foreign PC, or a conflicting PC with the same index bits and a different tag. After each injection it drains the output, so that every dropped or restarted address shows up in the scoreboard. Stalls hold `pfReady` low for several cycles in the middle of a burst. Interleaved and negative-stride streams cover the arithmetic.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // start a burst from the current access
    logic step;   // advance to the next predicted address
    logic abort;  // access without confidence: drop the burst
  } pfStrobe_t;
endpackage

// File: rtl/stride_pf_data.sv
module stride_pf_data
  import stride_pf_pkg::*;
#(
  parameter int PC_W          = 32,
  parameter int ADDR_W        = 32,
  parameter int PC_LSB        = 2,
  parameter int IDX_W         = 4,
  parameter int TAG_W         = 6,
  parameter int CNT_W         = 2,
  parameter int THRESH        = 2,
  parameter bit CLEAR_ON_MISS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [PC_W-1:0]   accPc,
  input  logic [ADDR_W-1:0] accAddr,
  input  pfStrobe_t         strobe,
  output logic              confident,
  output logic [ADDR_W-1:0] pfAddr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              entValid  [ENTRIES];
  logic [TAG_W-1:0]  entTag    [ENTRIES];
  logic [ADDR_W-1:0] entLast   [ENTRIES];
  logic [ADDR_W-1:0] entStride [ENTRIES];
  logic [CNT_W-1:0]  entCnt    [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit;
  logic              strideMatch;
  logic [ADDR_W-1:0] newStride;
  logic [ADDR_W-1:0] nextStride;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  missCnt;
  logic [ADDR_W-1:0] genAddr;
  logic [ADDR_W-1:0] genStride;

  assign idx         = accPc[PC_LSB +: IDX_W];
  assign tag         = accPc[PC_LSB+IDX_W +: TAG_W];
  assign hit         = entValid[idx] && (entTag[idx] == tag);
  assign newStride   = accAddr - entLast[idx];
  assign strideMatch = (newStride == entStride[idx]);

  // count after a stride mismatch: variant picked by parameter
  generate
    if (CLEAR_ON_MISS) begin : g_clear
      assign missCnt = '0;
    end else begin : g_dec
      assign missCnt = (entCnt[idx] == '0) ? '0 : entCnt[idx] - 1'b1;
    end
  endgenerate

  always_comb begin
    if (!hit) begin
      nextCnt    = '0;
      nextStride = '0;
    end else if (strideMatch) begin
      nextCnt    = (entCnt[idx] == CNT_MAX) ? CNT_MAX : entCnt[idx] + 1'b1;
      nextStride = newStride;
    end else begin
      nextCnt    = missCnt;
      nextStride = newStride;
    end
  end

  assign confident = accValid && hit && (32'(nextCnt) > THRESH) && (nextStride != '0);

  // table valid bits (reset)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) entValid[i] <= 1'b0;
    end else if (accValid) begin
      entValid[idx] <= 1'b1;
    end
  end

  // table payload
  always_ff @(posedge clk) begin
    if (accValid) begin
      entTag[idx]    <= tag;
      entLast[idx]   <= accAddr;
      entStride[idx] <= nextStride;
      entCnt[idx]    <= nextCnt;
    end
  end

  // prefetch address generator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      genAddr   <= '0;
      genStride <= '0;
    end else if (strobe.load) begin
      genAddr   <= accAddr + nextStride;
      genStride <= nextStride;
    end else if (strobe.step) begin
      genAddr   <= genAddr + genStride;
    end
  end

  assign pfAddr = genAddr;

  // every access leaves its address as the entry's last address
  p_last_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> entLast[$past(idx)] == $past(accAddr));

  // count stays saturated on a repeat
  p_cnt_saturates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && hit && strideMatch && entCnt[idx] == CNT_MAX)
      |=> entCnt[$past(idx)] == CNT_MAX);

  // a replaced entry starts from zero confidence
  p_replace_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !hit) |=> (entCnt[$past(idx)] == '0 && entStride[$past(idx)] == '0));
endmodule

// File: rtl/stride_pf_ctrl.sv
module stride_pf_ctrl
  import stride_pf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accValid,
  input  logic      confident,
  input  logic      pfReady,
  output pfStrobe_t strobe,
  output logic      pfValid
);
  localparam int REM_W = $clog2(DEPTH + 1);
  localparam logic [REM_W-1:0] REM_FULL = REM_W'(DEPTH);

  logic [REM_W-1:0] remaining;

  assign pfValid      = (remaining != '0);
  assign strobe.load  = accValid && confident;
  assign strobe.abort = accValid && !confident;
  assign strobe.step  = pfValid && pfReady && !accValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (strobe.load) begin
      remaining <= REM_FULL;
    end else if (strobe.abort) begin
      remaining <= '0;
    end else if (strobe.step) begin
      remaining <= remaining - 1'b1;
    end
  end

  // no offer appears without an access behind it
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfValid && !accValid) |=> !pfValid);

  // burst never longer than the depth
  p_burst_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    remaining <= REM_FULL);
endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int PC_W          = 32,
  parameter int ADDR_W        = 32,
  parameter int PC_LSB        = 2,
  parameter int IDX_W         = 4,
  parameter int TAG_W         = 6,
  parameter int CNT_W         = 2,
  parameter int THRESH        = 2,
  parameter int DEPTH         = 4,
  parameter bit CLEAR_ON_MISS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [PC_W-1:0]   accPc,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [ADDR_W-1:0] pfAddr
);
  pfStrobe_t strobe;
  logic      confident;

  stride_pf_data #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W),
    .TAG_W(TAG_W), .CNT_W(CNT_W), .THRESH(THRESH), .CLEAR_ON_MISS(CLEAR_ON_MISS)
  ) data_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accPc(accPc),
    .accAddr(accAddr), .strobe(strobe), .confident(confident), .pfAddr(pfAddr)
  );

  stride_pf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .confident(confident),
    .pfReady(pfReady), .strobe(strobe), .pfValid(pfValid)
  );

  // stalled offer holds
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && !pfReady && !accValid) |=> (pfValid && $stable(pfAddr)));

  // unconfident access ends any burst
  p_abort_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !confident) |=> !pfValid);

  // a burst only begins right after an access
  p_start_follows_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfValid) |-> $past(accValid));
endmodule

// File: tb/stride_pf_table_tb_top.sv
module stride_pf_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accPc = '0;
  logic [31:0] accAddr = '0;
  logic        pfValid;
  logic        pfReady = 1'b0;
  logic [31:0] pfAddr;

  always #4 clk = ~clk; // 125 MHz

  stride_pf_table dut_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accPc(accPc),
    .accAddr(accAddr), .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] expQ[$];

  // reference model of the table
  bit          mValid [16];
  logic [5:0]  mTag   [16];
  logic [31:0] mLast  [16];
  logic [31:0] mStride[16];
  int          mCnt   [16];

  task automatic report(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelAccess(input logic [31:0] pc, input logic [31:0] addr);
    int i = int'(pc[5:2]);
    logic [5:0] t = pc[11:6];
    bit h = mValid[i] && (mTag[i] == t);
    logic [31:0] s;
    if (h) begin
      s = addr - mLast[i];
      if (s == mStride[i]) mCnt[i] = (mCnt[i] == 3) ? 3 : mCnt[i] + 1;
      else mCnt[i] = (mCnt[i] == 0) ? 0 : mCnt[i] - 1;
      mStride[i] = s;
    end else begin
      mValid[i] = 1'b1; mTag[i] = t; mStride[i] = '0; mCnt[i] = 0;
    end
    mLast[i] = addr;
    expQ.delete();
    if (h && mCnt[i] > 2 && mStride[i] != '0)
      for (int k = 1; k <= 4; k++) expQ.push_back(addr + 32'(k) * mStride[i]);
  endtask

  // one cycle: compare the outputs, then drive the next inputs
  task automatic tick(input bit v, input logic [31:0] pc, input logic [31:0] addr,
                      input bit rdy, input string req);
    @(negedge clk);
    if (pfValid) begin
      report(expQ.size() > 0 && expQ[0] == pfAddr, req, pfAddr,
             expQ.size() > 0 ? expQ[0] : 32'hxxxxxxxx);
      if (rdy && !v && expQ.size() > 0) void'(expQ.pop_front());
    end else begin
      report(expQ.size() == 0, req, 32'(pfValid), 32'(expQ.size() != 0));
    end
    accValid = v; accPc = pc; accAddr = addr; pfReady = rdy;
    if (v) modelAccess(pc, addr);
  endtask

  task automatic idle(input int n, input bit rdy, input string req);
    for (int k = 0; k < n; k++) tick(1'b0, '0, '0, rdy, req);
  endtask

  task automatic access(input logic [31:0] pc, input logic [31:0] addr, input string req);
    tick(1'b1, pc, addr, 1'b1, req);
  endtask

  localparam logic [31:0] PC_A  = 32'h0000_0104; // index 1, tag 4
  localparam logic [31:0] PC_A2 = 32'h0000_0144; // index 1, tag 5
  localparam logic [31:0] PC_B  = 32'h0000_0208;
  localparam logic [31:0] PC_C  = 32'h0000_030C;
  localparam logic [31:0] PC_X  = 32'h0000_0114;
  localparam logic [31:0] PC_Y  = 32'h0000_0118;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) begin mValid[i] = 0; mCnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1'b1, "R1");

    // R6/R7: steady stream, fifth access triggers
    for (int k = 0; k < 5; k++) access(PC_A, 32'h1000 + 32'(k) * 64, "R6");
    idle(6, 1'b1, "R7");

    // R9: stalls during a burst
    access(PC_A, 32'h1000 + 5 * 64, "R4");
    idle(3, 1'b0, "R9");
    idle(6, 1'b1, "R9");

    // R10: continuing access mid-burst restarts, foreign PC aborts
    access(PC_A, 32'h1000 + 6 * 64, "R10");
    idle(2, 1'b1, "R10");
    access(PC_A, 32'h1000 + 7 * 64, "R10");
    idle(1, 1'b1, "R10");
    access(PC_B, 32'h9000, "R10");
    idle(3, 1'b1, "R10");

    // R8: zero stride with high count
    for (int k = 0; k < 7; k++) access(PC_B, 32'h9000, "R8");
    idle(3, 1'b1, "R8");

    // R3: negative stride
    for (int k = 0; k < 5; k++) access(PC_C, 32'h8000 - 32'(k) * 32, "R3");
    idle(6, 1'b1, "R3");

    // R11: interleaved streams
    for (int k = 0; k < 5; k++) begin
      access(PC_X, 32'h2_0000 + 32'(k) * 16, "R11");
      access(PC_Y, 32'h3_0000 + 32'(k) * 128, "R11");
      access(PC_C, 32'h8000 - 32'(k + 5) * 32, "R11");
    end
    idle(6, 1'b1, "R11");

    // R5: one mismatch only drops the count by one
    access(PC_A, 32'h1000 + 8 * 64, "R5");
    access(PC_A, 32'h1000 + 8 * 64 + 256, "R5");
    access(PC_A, 32'h1000 + 8 * 64 + 512, "R5");
    idle(6, 1'b1, "R5");

    // R12/R2: same index, other tag evicts
    access(PC_A2, 32'h5000, "R2");
    access(PC_A, 32'h1000 + 8 * 64 + 768, "R12");
    idle(2, 1'b1, "R12");
    access(PC_A, 32'h1000 + 8 * 64 + 1024, "R12");
    idle(3, 1'b1, "R12");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule